// File: doc/BRIEF.md
# Five-Phase Multi-Cycle Load-Store Core

This block is a small, non-pipelined 32-bit core. Every instruction takes one cycle in each of five phases, always in the same order: fetch, decode with register read, execute or address calculation, memory access, and write back. The next instruction is fetched only after the current one has written back. Values pass from one phase to the next through dedicated latches: the instruction word, the next-PC value, the two operand latches, the sign-extended immediate, the ALU result and the loaded data.

The core decodes a register-register format and a register-immediate format. It supports add, subtract, and, or and xor between registers, add-immediate, load word and store word. Instruction and data memories are internal word arrays indexed by address bits [9:2]. While reset is held, a load port fills either array. A halt instruction (all ones) stops the sequencer. Combinational peek ports read back any register and any data word, and the write strobes are visible at the ports.

Top module: `mc_core`

## Requirements
- R1: While reset is low and in the first cycle after it is released, the phase is fetch (phase_o code 0), pc_o is 0 and halt_o is 0.
- R2: phase_o steps one code per clock through fetch 0, decode 1, execute 2, memory 3, write back 4, then returns to 0. pc_o changes only at the end of write back, where it becomes its old value plus 4. An instruction therefore takes exactly 5 cycles.
- R3: Opcode 0x00 (bits [31:26]) is register-register. rs1 is [25:21], rs2 is [20:16] and rd is [15:11]. Function bits [5:0] select the operation: 0x20 add, 0x22 subtract (rs1 minus rs2), 0x24 and, 0x25 or, 0x26 xor. The result is written to rd.
- R4: Opcode 0x08 writes rs1 plus the sign-extended immediate [15:0] into the register at bits [20:16].
- R5: Opcode 0x23 loads the data word at index ((rs1 + sign-extended immediate) bits [9:2]) into the register at bits [20:16]. A load that follows a store sees the stored value.
- R6: Opcode 0x2B writes the register at bits [20:16] into the data word at index ((rs1 + sign-extended immediate) bits [9:2]). It writes no register.
- R7: Register 0 always reads as zero. A write aimed at it changes nothing and raises no rf_we_o.
- R8: Any other opcode, and any register-register function code not listed in R3, writes neither a register nor memory, and the PC still advances by 4.
- R9: When the fetched word is all ones, halt_o rises on the next cycle and stays high. The phase holds at code 5, pc_o keeps the address of the halt word, and no further writes occur.
- R10: rf_we_o is high only in write back, and dmem_we_o is high only in memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_we_i | input | 1 | Memory preload write strobe |
| load_imem_i | input | 1 | Preload target: 1 instruction array, 0 data array |
| load_addr_i | input | 8 | Preload word index |
| load_data_i | input | 32 | Preload word |
| reg_peek_addr_i | input | 5 | Register read-back index |
| reg_peek_o | output | 32 | Register read-back value |
| mem_peek_addr_i | input | 8 | Data word read-back index |
| mem_peek_o | output | 32 | Data word read-back value |
| pc_o | output | 32 | Program counter |
| phase_o | output | 3 | Current phase code |
| halt_o | output | 1 | Core halted |
| rf_we_o | output | 1 | Register write this cycle |
| rf_waddr_o | output | 5 | Register write index |
| rf_wdata_o | output | 32 | Register write value |
| dmem_we_o | output | 1 | Data memory write this cycle |

## Verification
The first instruction is traced one cycle at a time to pin down the phase codes, the single PC step and the write-back strobe. The bench then runs a program whose two operands, 7 and -3, differ in sign and in their low bits, so each of add, subtract, and, or and xor gives a distinct result. The immediate cases include a negative store offset and an add aimed at register 0. The program also contains an unknown opcode, an unknown function code, and a load placed after a store to the same word, which separates forwarding of memory contents from a stale read. The write count, the cycle count to halt and the frozen state after halt confirm that no extra or missing phases occur.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
  localparam int ILEN = 32;
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);

  typedef enum logic [2:0] {
    PH_IF   = 3'd0,
    PH_ID   = 3'd1,
    PH_EX   = 3'd2,
    PH_MEM  = 3'd3,
    PH_WB   = 3'd4,
    PH_HALT = 3'd5
  } phase_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR
  } alu_op_e;

  localparam logic [5:0] OP_RR   = 6'h00;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_LW   = 6'h23;
  localparam logic [5:0] OP_SW   = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
endpackage

// File: rtl/mc_seq.sv
`timescale 1ns/1ps
module mc_seq
  import mc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   halt_fetch_i,
  output phase_e phase_o
);
  phase_e phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IF;
    else begin
      unique case (phase_q)
        PH_IF:   phase_q <= halt_fetch_i ? PH_HALT : PH_ID;
        PH_ID:   phase_q <= PH_EX;
        PH_EX:   phase_q <= PH_MEM;
        PH_MEM:  phase_q <= PH_WB;
        PH_WB:   phase_q <= PH_IF;
        default: phase_q <= PH_HALT;
      endcase
    end
  end

  assign phase_o = phase_q;

  p_fetch_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IF) |=> (phase_q == PH_ID || phase_q == PH_HALT));
  p_wb_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_WB) |=> (phase_q == PH_IF));
  p_halt_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HALT) |=> (phase_q == PH_HALT));
endmodule

// File: rtl/mc_alu.sv
`timescale 1ns/1ps
module mc_alu
  import mc_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_XOR: y_o = a_i ^ b_i;
      default: y_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/mc_regfile.sv
`timescale 1ns/1ps
module mc_regfile #(
  parameter int NR = 32,
  parameter int DW = 32,
  parameter int AW = $clog2(NR)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  input  logic [AW-1:0] rp_i,
  output logic [DW-1:0] ra_o,
  output logic [DW-1:0] rb_o,
  output logic [DW-1:0] rp_o
);
  logic [DW-1:0] regs_q [NR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) regs_q <= '{default: '0};
    else if (we_i && waddr_i != '0) regs_q[waddr_i] <= wdata_i;
  end

  assign ra_o = regs_q[ra_i];
  assign rb_o = regs_q[rb_i];
  assign rp_o = regs_q[rp_i];

  // r0 must survive an attempted write
  p_r0_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i == '0) |=> (regs_q[0] == '0));
endmodule

// File: rtl/mc_core.sv
`timescale 1ns/1ps
module mc_core
  import mc_pkg::*;
#(
  parameter int MEM_WORDS = 256,
  parameter int AW        = $clog2(MEM_WORDS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_we_i,
  input  logic            load_imem_i,
  input  logic [AW-1:0]   load_addr_i,
  input  logic [ILEN-1:0] load_data_i,
  input  logic [RAW-1:0]  reg_peek_addr_i,
  output logic [ILEN-1:0] reg_peek_o,
  input  logic [AW-1:0]   mem_peek_addr_i,
  output logic [ILEN-1:0] mem_peek_o,
  output logic [ILEN-1:0] pc_o,
  output logic [2:0]      phase_o,
  output logic            halt_o,
  output logic            rf_we_o,
  output logic [RAW-1:0]  rf_waddr_o,
  output logic [ILEN-1:0] rf_wdata_o,
  output logic            dmem_we_o
);
  localparam int DW = ILEN;

  logic [DW-1:0] imem [MEM_WORDS];
  logic [DW-1:0] dmem [MEM_WORDS];

  // inter-phase latches
  logic [DW-1:0] pc_q, npc_q, ir_q, a_q, b_q, imm_q, alu_q, lmd_q;

  phase_e  phase;
  alu_op_e alu_op;
  logic    use_imm, wr_en, is_lw, is_sw;
  logic [RAW-1:0] wr_addr;
  logic [DW-1:0]  fetch_word, rs1_val, rs2_val, alu_y;
  logic [AW-1:0]  pc_idx, ea_idx;

  assign pc_idx     = pc_q[AW+1:2];
  assign ea_idx     = alu_q[AW+1:2];
  assign fetch_word = imem[pc_idx];

  mc_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .halt_fetch_i (phase == PH_IF && fetch_word == '1),
    .phase_o      (phase)
  );

  always_comb begin
    alu_op  = ALU_ADD;
    use_imm = 1'b1;
    wr_en   = 1'b0;
    wr_addr = ir_q[20:16];
    is_lw   = 1'b0;
    is_sw   = 1'b0;
    unique case (ir_q[31:26])
      OP_RR: begin
        use_imm = 1'b0;
        wr_addr = ir_q[15:11];
        wr_en   = 1'b1;
        unique case (ir_q[5:0])
          FN_ADD:  alu_op = ALU_ADD;
          FN_SUB:  alu_op = ALU_SUB;
          FN_AND:  alu_op = ALU_AND;
          FN_OR:   alu_op = ALU_OR;
          FN_XOR:  alu_op = ALU_XOR;
          default: wr_en  = 1'b0;
        endcase
      end
      OP_ADDI: wr_en = 1'b1;
      OP_LW: begin
        is_lw = 1'b1;
        wr_en = 1'b1;
      end
      OP_SW:   is_sw = 1'b1;
      default: ;
    endcase
  end

  mc_regfile #(.NR(NREG), .DW(DW)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we_o),
    .waddr_i (wr_addr),
    .wdata_i (rf_wdata_o),
    .ra_i    (ir_q[25:21]),
    .rb_i    (ir_q[20:16]),
    .rp_i    (reg_peek_addr_i),
    .ra_o    (rs1_val),
    .rb_o    (rs2_val),
    .rp_o    (reg_peek_o)
  );

  mc_alu #(.DW(DW)) u_alu (
    .op_i (alu_op),
    .a_i  (a_q),
    .b_i  (use_imm ? imm_q : b_q),
    .y_o  (alu_y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      npc_q <= '0;
      ir_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      imm_q <= '0;
      alu_q <= '0;
      lmd_q <= '0;
    end else begin
      unique case (phase)
        PH_IF: begin
          ir_q  <= fetch_word;
          npc_q <= pc_q + 32'd4;
        end
        PH_ID: begin
          a_q   <= rs1_val;
          b_q   <= rs2_val;
          imm_q <= {{16{ir_q[15]}}, ir_q[15:0]};
        end
        PH_EX:  alu_q <= alu_y;
        PH_MEM: if (is_lw) lmd_q <= dmem[ea_idx];
        PH_WB:  pc_q <= npc_q;
        default: ;
      endcase
    end
  end

  // memories: core store wins over preload
  always_ff @(posedge clk_i) begin
    if (dmem_we_o) dmem[ea_idx] <= b_q;
    else if (load_we_i && !load_imem_i) dmem[load_addr_i] <= load_data_i;
    if (load_we_i && load_imem_i) imem[load_addr_i] <= load_data_i;
  end

  assign dmem_we_o  = (phase == PH_MEM) && is_sw;
  assign rf_we_o    = (phase == PH_WB) && wr_en && (wr_addr != '0);
  assign rf_waddr_o = wr_addr;
  assign rf_wdata_o = is_lw ? lmd_q : alu_q;
  assign mem_peek_o = dmem[mem_peek_addr_i];
  assign pc_o       = pc_q;
  assign phase_o    = phase;
  assign halt_o     = (phase == PH_HALT);

  p_pc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_WB) |=> (pc_q == $past(pc_q) + 32'd4));
  p_pc_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != PH_WB) |=> $stable(pc_q));
  p_rf_we_wb_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (phase == PH_WB));
  p_dmem_we_mem_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> (phase == PH_MEM));
  p_halt_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> (!rf_we_o && !dmem_we_o));
endmodule

// File: tb/mc_core_test.sv
`timescale 1ns/1ps
module mc_core_test;
  import mc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_we = 1'b0, load_imem = 1'b0;
  logic [7:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic [4:0]  reg_peek_addr = '0;
  logic [31:0] reg_peek;
  logic [7:0]  mem_peek_addr = '0;
  logic [31:0] mem_peek, pc;
  logic [2:0]  phase;
  logic        halt, rf_we, dmem_we;
  logic [4:0]  rf_waddr;
  logic [31:0] rf_wdata;

  int n_tests = 0, n_fail = 0;
  int cyc = 0, rf_writes = 0, r0_writes = 0, st_writes = 0;

  always #10 clk = ~clk;

  mc_core uut (
    .clk_i (clk), .rst_ni (rst_n),
    .load_we_i (load_we), .load_imem_i (load_imem),
    .load_addr_i (load_addr), .load_data_i (load_data),
    .reg_peek_addr_i (reg_peek_addr), .reg_peek_o (reg_peek),
    .mem_peek_addr_i (mem_peek_addr), .mem_peek_o (mem_peek),
    .pc_o (pc), .phase_o (phase), .halt_o (halt),
    .rf_we_o (rf_we), .rf_waddr_o (rf_waddr), .rf_wdata_o (rf_wdata),
    .dmem_we_o (dmem_we)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n) begin
    if (rf_we) rf_writes <= rf_writes + 1;
    if (rf_we && rf_waddr == 5'd0) r0_writes <= r0_writes + 1;
    if (dmem_we) st_writes <= st_writes + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(logic [4:0] rs1, logic [4:0] rs2, logic [4:0] rd, logic [5:0] fn);
    return {OP_RR, rs1, rs2, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs1, logic [4:0] rd, logic [15:0] imm);
    return {op, rs1, rd, imm};
  endfunction

  task automatic put(input logic to_imem, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    load_we = 1'b1; load_imem = to_imem; load_addr = a; load_data = d;
    @(negedge clk);
    load_we = 1'b0;
  endtask

  task automatic peek_reg(input logic [4:0] r, output logic [31:0] v);
    reg_peek_addr = r; #1; v = reg_peek;
  endtask

  task automatic peek_mem(input logic [7:0] a, output logic [31:0] v);
    mem_peek_addr = a; #1; v = mem_peek;
  endtask

  task automatic t_load_program;
    put(1'b0, 8'd4, 32'h1234_5678);
    put(1'b1, 8'd0,  enc_i(OP_ADDI, 5'd0, 5'd1, 16'd7));
    put(1'b1, 8'd1,  enc_i(OP_ADDI, 5'd0, 5'd2, 16'hFFFD));
    put(1'b1, 8'd2,  enc_r(5'd1, 5'd2, 5'd3, FN_ADD));
    put(1'b1, 8'd3,  enc_r(5'd1, 5'd2, 5'd4, FN_SUB));
    put(1'b1, 8'd4,  enc_r(5'd1, 5'd2, 5'd5, FN_AND));
    put(1'b1, 8'd5,  enc_r(5'd1, 5'd2, 5'd6, FN_OR));
    put(1'b1, 8'd6,  enc_r(5'd1, 5'd2, 5'd7, FN_XOR));
    put(1'b1, 8'd7,  enc_i(OP_LW, 5'd3, 5'd8, 16'd12));
    put(1'b1, 8'd8,  enc_i(OP_SW, 5'd4, 5'd7, 16'hFFFE));
    put(1'b1, 8'd9,  enc_i(OP_ADDI, 5'd0, 5'd0, 16'd5));
    put(1'b1, 8'd10, 32'hFC00_0000);
    put(1'b1, 8'd11, enc_r(5'd1, 5'd2, 5'd9, 6'h00));
    put(1'b1, 8'd12, enc_i(OP_LW, 5'd0, 5'd10, 16'd8));
    put(1'b1, 8'd13, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk("R1 phase", {29'd0, phase}, 32'd0);
    chk("R1 pc", pc, 32'd0);
    chk("R1 halt", {31'd0, halt}, 32'd0);
  endtask

  task automatic t_first_instr;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 phase after release", {29'd0, phase}, 32'd0);
    for (int k = 0; k < 5; k++) begin
      if (k > 0) begin @(negedge clk); #1; end
      chk("R2 phase code", {29'd0, phase}, k);
      chk("R2 pc held", pc, 32'd0);
      chk("R10 rf_we only in WB", {31'd0, rf_we}, (k == 4) ? 32'd1 : 32'd0);
    end
    chk("R4 wb index", {27'd0, rf_waddr}, 32'd1);
    chk("R4 wb value", rf_wdata, 32'd7);
    @(negedge clk); #1;
    chk("R2 back to fetch", {29'd0, phase}, 32'd0);
    chk("R2 pc step", pc, 32'd4);
  endtask

  task automatic t_run_to_halt;
    int guard = 0;
    while (!halt && guard < 2000) begin @(negedge clk); #1; guard++; end
    chk("R9 halt reached", {31'd0, halt}, 32'd1);
    chk("R2 five cycles per instruction", cyc, 66);
    chk("R9 pc at halt word", pc, 32'd52);
    chk("R9 halt phase code", {29'd0, phase}, 32'd5);
  endtask

  task automatic t_check_regs;
    logic [31:0] v;
    peek_reg(5'd1, v);  chk("R4 addi positive", v, 32'd7);
    peek_reg(5'd2, v);  chk("R4 addi sign-extended", v, 32'hFFFF_FFFD);
    peek_reg(5'd3, v);  chk("R3 add", v, 32'd4);
    peek_reg(5'd4, v);  chk("R3 sub", v, 32'd10);
    peek_reg(5'd5, v);  chk("R3 and", v, 32'd5);
    peek_reg(5'd6, v);  chk("R3 or", v, 32'hFFFF_FFFF);
    peek_reg(5'd7, v);  chk("R3 xor", v, 32'hFFFF_FFFA);
    peek_reg(5'd8, v);  chk("R5 load word", v, 32'h1234_5678);
    peek_reg(5'd0, v);  chk("R7 r0 reads zero", v, 32'd0);
    peek_reg(5'd9, v);  chk("R8 bad function no write", v, 32'd0);
    peek_reg(5'd10, v); chk("R5 load after store", v, 32'hFFFF_FFFA);
    chk("R7 no r0 write strobe", r0_writes, 0);
    chk("R8 write count", rf_writes, 9);
  endtask

  task automatic t_check_mem;
    logic [31:0] v;
    peek_mem(8'd2, v); chk("R6 store negative offset", v, 32'hFFFF_FFFA);
    peek_mem(8'd4, v); chk("R6 other word untouched", v, 32'h1234_5678);
    peek_mem(8'd1, v); chk("R6 neighbour untouched", v, 32'd0);
    chk("R6 single store strobe", st_writes, 1);
  endtask

  task automatic t_halt_hold;
    int w0 = rf_writes;
    repeat (10) @(negedge clk);
    #1;
    chk("R9 halt stays", {31'd0, halt}, 32'd1);
    chk("R9 pc frozen", pc, 32'd52);
    chk("R9 no writes after halt", rf_writes - w0, 0);
  endtask

  initial begin
    #(200000 * 20);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_load_program();
    t_reset();
    t_first_instr();
    t_run_to_halt();
    t_check_regs();
    t_check_mem();
    t_halt_hold();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule